// File: doc/BRIEF.md
# Four-Channel TDM PCM Serial Port

This block connects four voice channels to a serial time-division PCM highway. Its master clock is also the bit clock. Eight-bit samples for each channel arrive on a parallel bus and leave serially on a transmit data line, most significant bit first. The port drives the line's output enable and an active-low slot indicator. Serial receive data is gathered into bytes. Each byte is handed out with a one-cycle strobe that carries the channel index.

There are two framing modes. In the per-channel mode, each channel has its own transmit and receive frame sync, and its slot starts from that sync. The sync may be a one-bit pulse or a pulse of two or more bits. The width of the channel-0 transmit pulse selects the timing used for every channel. In the consecutive mode, the channel-0 syncs open one 32-bit transfer that carries channels 0 to 3 in order. Two carry pulses mark the last bit of that transfer so that a second device can take the following four slots. Per-channel power-down inputs mute a channel's slot in both directions.

All timing is counted in clock edges. An edge numbered k is the first rising edge at which a sync input is seen high after being low.

Top module: `pcm_tdm_port`

## Requirements
- R1: Transmit bits leave MSB first, sample bit 7 first. In the consecutive mode, the four bytes follow one another with channel 0 first. Channel c's sample sits at bits [8c+7:8c] of `tx_samples`.
- R2: One-bit sync format. After edge k of a transmit sync, `dx_oe` is high and `tsx_n` is low from the output of edge k+1 through the output of edge k+8, and both return to idle after edge k+9.
- R3: One-bit sync format, receive side. `dr` is sampled at edges k+1 to k+8, first bit as MSB. The byte appears on `rx_data` with `rx_valid` high for one cycle after edge k+8, with the channel on `rx_ch`.
- R4: When a channel-0 transmit sync is high for 2 or more edges, the two-bit-or-wider format applies to all channels from the next frame. In that format both directions run one edge earlier: transmit drives after edges k..k+7, and receive samples at edges k..k+7. A one-edge pulse on channel 0 returns to the one-bit format.
- R5: In the per-channel mode, a slot belongs to the channel whose own sync rose. Transmit and receive may serve different channels in the same frame.
- R6: During the slot of a channel whose `pd` bit is high, `dx_oe` stays low, `tsx_n` stays high and no `rx_valid` is produced for that channel.
- R7: With `mode32` high, a rising `fsx[0]`/`fsr[0]` always uses the one-bit format. Starting at edge k+1, it runs 32 consecutive bits covering channels 0,1,2,3. A receive byte is strobed after each eighth bit.
- R8: In the consecutive mode, `fsx_co` is high for exactly the cycle in which the last transmit bit is driven (after edge k+32). `fsr_co` is high for exactly the cycle that ends with the capture of the last receive bit (after edge k+31). Both pulses occur even when every channel is powered down, and both stay low in the per-channel mode.
- R9: While `rst` is high, `dx_oe` and `dx` are low, `tsx_n` is high, and both carry pulses and `rx_valid` are low. The format is one-bit after reset.
- R10: With `mode32` high, syncs on channels 1 to 3 start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master and bit clock |
| rst | input | 1 | Synchronous active-high reset |
| mode32 | input | 1 | 1: consecutive 32-bit mode, 0: per-channel mode |
| pd | input | 4 | Per-channel power-down, active high |
| tx_samples | input | 32 | Transmit samples, channel c at [8c+7:8c] |
| fsx | input | 4 | Transmit frame syncs per channel |
| fsr | input | 4 | Receive frame syncs per channel |
| dr | input | 1 | Serial receive data |
| dx | output | 1 | Serial transmit data (low when not enabled) |
| dx_oe | output | 1 | Transmit output enable |
| tsx_n | output | 1 | Active-low transmit slot indicator |
| fsx_co | output | 1 | Transmit carry frame pulse (32-bit mode) |
| fsr_co | output | 1 | Receive carry frame pulse (32-bit mode) |
| rx_data | output | 8 | Last completed received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_ch | output | 2 | Channel of `rx_data` |

## Verification
The bench switches between the one-bit and the wider sync format through the channel-0 pulse width. A design that applied the new format in the same frame, or that ignored the format, would put the enable window one edge off and shift every data bit. Powered-down slots are checked in both modes, including a frame with every channel down. That frame would expose a carry pulse tied to data activity and not to the bit count. Syncs on channels 1 to 3 are also pulsed in consecutive mode, where a design that left them live would open an extra slot. The two carry pulses are checked one cycle apart, which catches an off-by-one between the transmit and receive bit counters.

// File: rtl/pcm_tdm_pkg.sv
package pcm_tdm_pkg;
  typedef enum logic {
    FMT_SHORT = 1'b0,
    FMT_LONG  = 1'b1
  } sync_fmt_e;
endpackage

// File: rtl/pcm_fmt_detect.sv
module pcm_fmt_detect
  import pcm_tdm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      fs,
  output sync_fmt_e fmt
);
  logic       fs_q;
  logic [1:0] width;

  // measure the high time of the reference sync, judge it when it falls
  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q  <= 1'b0;
      width <= '0;
      fmt   <= FMT_SHORT;
    end else begin
      fs_q <= fs;
      if (fs) begin
        if (width != 2'd3) width <= width + 2'd1;
      end else begin
        width <= '0;
        if (fs_q) fmt <= (width >= 2'd2) ? FMT_LONG : FMT_SHORT;
      end
    end
  end
endmodule

// File: rtl/pcm_sync_start.sv
module pcm_sync_start #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] fs,
  input  logic           mode32,
  input  logic           long_fmt,
  output logic           start,
  output logic [CHW-1:0] start_ch
);
  logic [NCH-1:0] fs_q, rise;
  logic           any_rise;
  logic [CHW-1:0] sel;
  logic           pend;
  logic [CHW-1:0] pend_ch;

  always_comb begin
    rise = fs & ~fs_q;
    if (mode32) rise = rise & {{(NCH-1){1'b0}}, 1'b1};
    sel      = '0;
    any_rise = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (rise[i]) begin
        sel      = CHW'(i);
        any_rise = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q    <= '0;
      pend    <= 1'b0;
      pend_ch <= '0;
    end else begin
      fs_q    <= fs;
      pend    <= any_rise & ~long_fmt;
      pend_ch <= sel;
    end
  end

  // wide syncs open the slot at the detecting edge, one-bit syncs one edge later
  assign start    = long_fmt ? any_rise : pend;
  assign start_ch = long_fmt ? sel : pend_ch;
endmodule

// File: rtl/pcm_tx_engine.sv
module pcm_tx_engine #(
  parameter int NCH = 4,
  parameter int SW  = 8,
  localparam int W   = NCH * SW,
  localparam int CW  = $clog2(W),
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode32,
  input  logic           start,
  input  logic [CHW-1:0] start_ch,
  input  logic [W-1:0]   samples,
  input  logic [NCH-1:0] pd,
  output logic           dx,
  output logic           dx_oe,
  output logic           tsx_n,
  output logic           carry
);
  logic           active;
  logic [CW-1:0]  cnt;
  logic [CHW-1:0] ch;
  logic [W-1:0]   sh;
  logic [W-1:0]   load;
  logic [CHW-1:0] cur_ch;
  logic [CW-1:0]  last;

  always_comb begin
    cur_ch = mode32 ? cnt[CW-1 -: CHW] : ch;
    last   = mode32 ? CW'(W - 1) : CW'(SW - 1);
    load   = '0;
    if (mode32) begin
      for (int i = 0; i < NCH; i++) load[W-1-i*SW -: SW] = samples[i*SW +: SW];
    end else begin
      load[W-1 -: SW] = samples[int'(start_ch)*SW +: SW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      ch     <= '0;
      sh     <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      ch     <= mode32 ? '0 : start_ch;
      sh     <= load;
    end else if (active) begin
      if (cnt == last) begin
        active <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
        sh  <= {sh[W-2:0], 1'b0};
      end
    end
  end

  assign dx_oe = active & ~pd[cur_ch];
  assign dx    = dx_oe & sh[W-1];
  assign tsx_n = ~dx_oe;
  assign carry = active & mode32 & (cnt == CW'(W - 1));

  // R2
  tx_slot_len_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !mode32) |-> (cnt < CW'(SW)));
endmodule

// File: rtl/pcm_rx_engine.sv
module pcm_rx_engine #(
  parameter int NCH = 4,
  parameter int SW  = 8,
  localparam int W   = NCH * SW,
  localparam int CW  = $clog2(W),
  localparam int CHW = $clog2(NCH),
  localparam int BW  = $clog2(SW)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode32,
  input  logic           start,
  input  logic [CHW-1:0] start_ch,
  input  logic           dr,
  input  logic [NCH-1:0] pd,
  output logic [SW-1:0]  rx_data,
  output logic           rx_valid,
  output logic [CHW-1:0] rx_ch,
  output logic           carry
);
  logic           active;
  logic [CW-1:0]  cnt;
  logic [CHW-1:0] ch;
  logic [SW-1:0]  sh;
  logic [CW-1:0]  cap_idx;
  logic [CHW-1:0] cap_ch;
  logic           capturing, byte_done;
  logic [SW-1:0]  next_byte;
  logic [CW-1:0]  last;

  always_comb begin
    last      = mode32 ? CW'(W - 1) : CW'(SW - 1);
    capturing = start | active;
    cap_idx   = start ? '0 : cnt;
    if (start)       cap_ch = mode32 ? '0 : start_ch;
    else if (mode32) cap_ch = cnt[CW-1 -: CHW];
    else             cap_ch = ch;
    byte_done = capturing & (cap_idx[BW-1:0] == {BW{1'b1}});
    next_byte = {sh[SW-2:0], dr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      cnt      <= '0;
      ch       <= '0;
      sh       <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_ch    <= '0;
    end else begin
      if (capturing) sh <= next_byte;
      if (start) begin
        active <= 1'b1;
        cnt    <= CW'(1);
        ch     <= mode32 ? '0 : start_ch;
      end else if (active) begin
        if (cap_idx == last) active <= 1'b0;
        else                 cnt    <= cnt + CW'(1);
      end
      rx_valid <= byte_done & ~pd[cap_ch];
      if (byte_done) begin
        rx_data <= next_byte;
        rx_ch   <= cap_ch;
      end
    end
  end

  assign carry = active & mode32 & (cnt == CW'(W - 1));

  // R6
  rx_pd_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !$past(pd[cap_ch]));
endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port
  import pcm_tdm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int SW  = 8,
  localparam int W   = NCH * SW,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode32,
  input  logic [NCH-1:0] pd,
  input  logic [W-1:0]   tx_samples,
  input  logic [NCH-1:0] fsx,
  input  logic [NCH-1:0] fsr,
  input  logic           dr,
  output logic           dx,
  output logic           dx_oe,
  output logic           tsx_n,
  output logic           fsx_co,
  output logic           fsr_co,
  output logic [SW-1:0]  rx_data,
  output logic           rx_valid,
  output logic [CHW-1:0] rx_ch
);
  sync_fmt_e      fmt;
  logic           long_eff;
  logic           tx_start, rx_start;
  logic [CHW-1:0] tx_start_ch, rx_start_ch;

  pcm_fmt_detect u_fmt (
    .clk (clk), .rst (rst), .fs (fsx[0]), .fmt (fmt)
  );

  assign long_eff = (fmt == FMT_LONG) & ~mode32;

  pcm_sync_start #(.NCH(NCH)) u_tx_sync (
    .clk (clk), .rst (rst), .fs (fsx), .mode32 (mode32), .long_fmt (long_eff),
    .start (tx_start), .start_ch (tx_start_ch)
  );

  pcm_sync_start #(.NCH(NCH)) u_rx_sync (
    .clk (clk), .rst (rst), .fs (fsr), .mode32 (mode32), .long_fmt (long_eff),
    .start (rx_start), .start_ch (rx_start_ch)
  );

  pcm_tx_engine #(.NCH(NCH), .SW(SW)) u_tx (
    .clk (clk), .rst (rst), .mode32 (mode32), .start (tx_start),
    .start_ch (tx_start_ch), .samples (tx_samples), .pd (pd),
    .dx (dx), .dx_oe (dx_oe), .tsx_n (tsx_n), .carry (fsx_co)
  );

  pcm_rx_engine #(.NCH(NCH), .SW(SW)) u_rx (
    .clk (clk), .rst (rst), .mode32 (mode32), .start (rx_start),
    .start_ch (rx_start_ch), .dr (dr), .pd (pd),
    .rx_data (rx_data), .rx_valid (rx_valid), .rx_ch (rx_ch), .carry (fsr_co)
  );

  // R8
  fsx_co_width_chk: assert property (@(posedge clk) disable iff (rst)
    fsx_co |=> !fsx_co);

  // R8
  fsr_co_width_chk: assert property (@(posedge clk) disable iff (rst)
    fsr_co |=> !fsr_co);
endmodule

// File: tb/pcm_tdm_port_test.sv
module pcm_tdm_port_test;
  localparam int NCH = 4;
  localparam int SW  = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        mode32;
  logic [3:0]  pd;
  logic [31:0] tx_samples;
  logic [3:0]  fsx, fsr;
  logic        dr;
  logic        dx, dx_oe, tsx_n, fsx_co, fsr_co, rx_valid;
  logic [7:0]  rx_data;
  logic [1:0]  rx_ch;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;
  bit  fmt_long_b = 0;

  // expectation record: {oe, dx, fsx_co, fsr_co, rx_valid}
  logic [4:0] exp_q[$];
  string      tag_q[$];
  logic [9:0] rx_q[$];

  always #4 clk = ~clk;

  pcm_tdm_port #(.NCH(NCH), .SW(SW)) uut (
    .clk (clk), .rst (rst), .mode32 (mode32), .pd (pd), .tx_samples (tx_samples),
    .fsx (fsx), .fsr (fsr), .dr (dr), .dx (dx), .dx_oe (dx_oe), .tsx_n (tsx_n),
    .fsx_co (fsx_co), .fsr_co (fsr_co), .rx_data (rx_data), .rx_valid (rx_valid),
    .rx_ch (rx_ch)
  );

  task automatic cmp(input string tag, input string what, input logic [9:0] got,
                     input logic [9:0] expv);
    checks++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, expv);
    end
  endtask

  // monitor: pops one expectation per clock, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [4:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        cmp(t, "dx_oe", {9'b0, dx_oe}, {9'b0, e[4]});
        cmp(t, "tsx_n (R2)", {9'b0, tsx_n}, {9'b0, ~e[4]});
        if (e[4]) cmp(t, "dx bit MSB first (R1)", {9'b0, dx}, {9'b0, e[3]});
        cmp(t, "fsx_co (R8)", {9'b0, fsx_co}, {9'b0, e[2]});
        cmp(t, "fsr_co (R8)", {9'b0, fsr_co}, {9'b0, e[1]});
        cmp(t, "rx_valid (R3)", {9'b0, rx_valid}, {9'b0, e[0]});
        if (rx_valid && rx_q.size() > 0) begin
          logic [9:0] r;
          r = rx_q.pop_front();
          cmp(t, "rx channel and byte (R3)", {rx_ch, rx_data}, r);
        end
      end
    end
  end

  task automatic drive(input logic [3:0] fx, input logic [3:0] fr, input logic d,
                       input logic [4:0] e, input string tag);
    @(negedge clk);
    fsx = fx;
    fsr = fr;
    dr  = d;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // per-channel frame; sync goes high at frame cycle 2 for w cycles
  task automatic frame8(input int txch, input int rxch, input int w,
                        input logic [7:0] rxb, input string tag);
    int s;
    s = fmt_long_b ? 2 : 3;
    if (rxch >= 0 && !pd[rxch]) rx_q.push_back({rxch[1:0], rxb});
    for (int j = 0; j < 16; j++) begin
      logic [3:0] fx, fr;
      logic       d;
      logic [4:0] e;
      fx = '0; fr = '0; d = 1'b0; e = '0;
      if (j >= 2 && j < 2 + w) begin
        if (txch >= 0) fx[txch] = 1'b1;
        if (rxch >= 0) fr[rxch] = 1'b1;
      end
      if (rxch >= 0 && j >= s && j < s + 8) d = rxb[7 - (j - s)];
      if (txch >= 0 && !pd[txch] && j >= s && j < s + 8) begin
        e[4] = 1'b1;
        e[3] = tx_samples[txch*8 + 7 - (j - s)];
      end
      if (rxch >= 0 && !pd[rxch] && j == s + 7) e[0] = 1'b1;
      drive(fx, fr, d, e, tag);
    end
    if (txch == 0) fmt_long_b = (w >= 2);
  endtask

  // consecutive-mode frame, one-bit sync at cycle 2
  task automatic frame32(input logic [31:0] rxw, input string tag);
    int s;
    s = 3;
    for (int b = 0; b < 4; b++)
      if (!pd[b]) rx_q.push_back({b[1:0], rxw[31 - 8*b -: 8]});
    for (int j = 0; j < 40; j++) begin
      logic [3:0] fx, fr;
      logic       d;
      logic [4:0] e;
      fx = '0; fr = '0; d = 1'b0; e = '0;
      if (j == 2) begin fx = 4'b0001; fr = 4'b0001; end
      if (j >= s && j < s + 32) begin
        int b, k;
        b = (j - s) / 8;
        k = (j - s) % 8;
        d = rxw[31 - (j - s)];
        if (!pd[b]) begin
          e[4] = 1'b1;
          e[3] = tx_samples[b*8 + 7 - k];
        end
        if (k == 7 && !pd[b]) e[0] = 1'b1;
      end
      if (j == s + 31) e[2] = 1'b1;
      if (j == s + 30) e[1] = 1'b1;
      drive(fx, fr, d, e, tag);
    end
    fmt_long_b = 0;
  endtask

  // consecutive mode: syncs on channels 1..3 must start nothing
  task automatic ignore32(input string tag);
    for (int j = 0; j < 24; j++) begin
      logic [3:0] fx;
      fx = (j == 2) ? 4'b1110 : 4'b0000;
      drive(fx, fx, 1'b1, 5'b0, tag);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mode32 = 1'b0; pd = '0; fsx = '0; fsr = '0; dr = 1'b0;
    tx_samples = {8'h3C, 8'hA5, 8'h96, 8'hC3};
    repeat (3) @(negedge clk);
    // R9 reset state
    cmp("R9", "reset dx_oe", {9'b0, dx_oe}, 10'd0);
    cmp("R9", "reset dx", {9'b0, dx}, 10'd0);
    cmp("R9", "reset tsx_n", {9'b0, tsx_n}, 10'd1);
    cmp("R9", "reset carries", {8'b0, fsx_co, fsr_co}, 10'd0);
    cmp("R9", "reset rx_valid", {9'b0, rx_valid}, 10'd0);
    rst = 1'b0;

    frame8(0, 0, 1, 8'h5A, "R2");   // one-bit sync, channel 0
    frame8(2, 1, 1, 8'h81, "R5");   // different channels per direction
    frame8(0, 3, 3, 8'hE7, "R3");   // still one-bit timing, arms wide format
    frame8(1, 2, 3, 8'h3C, "R4");   // wide format timing
    frame8(0, 0, 3, 8'hC9, "R4");
    pd = 4'b0010;
    frame8(1, 1, 1, 8'hFF, "R6");   // powered-down slot in wide format
    pd = 4'b0000;
    frame8(0, 0, 1, 8'h0F, "R4");   // wide timing, then back to one-bit
    frame8(3, 3, 1, 8'hB4, "R2");

    mode32 = 1'b1;
    frame32(32'h1234_ABCD, "R7");
    pd = 4'b0100;
    frame32(32'hF00F_5AA5, "R6");
    pd = 4'b1111;
    frame32(32'hDEAD_BEEF, "R8");
    pd = 4'b0000;
    ignore32("R10");
    mode32 = 1'b0;
    frame8(0, 0, 1, 8'h66, "R8");   // carries stay low in per-channel mode

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule